// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead Time

This block sits between a control loop and the two gate-drive enables of a half bridge. It takes either a separate pair of high-side and low-side request lines or a single PWM line. It produces two registered enables, `drv_hi` and `drv_lo`. In the interlocked modes the two enables are never high together. Each turn-on of an enable waits a programmable number of clock cycles after the opposite enable has gone low. Each turn-off takes effect on the next clock edge.

A third mode serves two unrelated low-side loads. In that mode each enable follows its own request one register stage later, with no interlock and no delay. A disable input overrides every mode. It forces both enables low and clears the pending dead-time counts, so a complete dead time is run again once the disable is released. The dead time comes from `dead_cfg` and is counted in clock cycles. A setting of zero gives the shortest possible dead time, one cycle.

Top module: `halfbridge_guard`

## Requirements
- R1: `mode_sel` picks the operating mode: 2'b00 is two-input interlocked, 2'b01 is single PWM input, 2'b10 is independent with no interlock, and 2'b11 behaves exactly like 2'b00.
- R2: In the interlocked modes (00, 01, 11), `drv_hi` and `drv_lo` are never both high on the cycle that follows.
- R3: In two-input mode, when `req_hi` and `req_lo` are both high, both enables are low after the next clock edge and remain low for as long as both requests stay high.
- R4: Let N be `dead_cfg`, or 1 when `dead_cfg` is 0. An interlocked enable rises on the Nth consecutive clock edge at which its request is sampled high while the opposite enable is low and not requested.
- R5: An enable whose request is low is low after the next clock edge. A request that drops before its count completes cancels the turn-on, and the next turn-on starts a fresh count.
- R6: In PWM mode, `pwm_in` high requests `drv_hi` and `pwm_in` low requests `drv_lo`. Every change of `pwm_in` gives one falling enable on the next edge and the opposite enable rising N edges later.
- R7: In independent mode, `drv_hi` and `drv_lo` each equal their own request as sampled at the previous clock edge, with no dead time and no interlock.
- R8: While `disable_in` is high, both enables are low after the next clock edge, in every mode. After release, a full dead time of N edges runs before an enable can rise.
- R9: While `rst_n` is low, both enables are low at once and the dead-time counts are cleared.
- R10: After two-input contention clears, the enable that is still requested rises only after a full dead time of N edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Mode selection (see R1) |
| disable_in | input | 1 | Forces both enables low |
| req_hi | input | 1 | High-side request (two-input and independent modes) |
| req_lo | input | 1 | Low-side request (two-input and independent modes) |
| pwm_in | input | 1 | Single PWM command (PWM mode) |
| dead_cfg | input | DT_W | Dead time in clock cycles; 0 selects one cycle |
| drv_hi | output | 1 | High-side gate enable |
| drv_lo | output | 1 | Low-side gate enable |

## Verification
The request lines are stepped through several sequences. A hand-off from high side to low side shows that the falling enable and the delayed rising enable are timed apart. A period with both requests high, followed by release to either side, separates simple contention blanking from the dead time that must follow recovery. A request withdrawn partway through its count shows whether the count is cancelled or only paused. The PWM patterns, run with a zero setting and a nonzero setting, test complementary derivation and the one-cycle minimum. The independent and disable patterns show the bypass path and the fresh count after release. A long directed count checks the exact edge for a setting of ten.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        HBG_DUAL     = 2'b00,
        HBG_PWM      = 2'b01,
        HBG_INDEP    = 2'b10,
        HBG_DUAL_ALT = 2'b11
    } hbg_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } hbg_want_t;

endpackage

// File: rtl/hbg_req_map.sv
module hbg_req_map
    import hbg_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       disable_in,
    input  logic       req_hi,
    input  logic       req_lo,
    input  logic       pwm_in,
    output hbg_want_t  want,
    output logic       interlock
);

    hbg_mode_e mode;

    always_comb begin
        mode = hbg_mode_e'(mode_sel);
        want = '0;
        interlock = 1'b1;
        unique case (mode)
            HBG_PWM: begin
                want.hi = pwm_in;
                want.lo = !pwm_in;
            end
            HBG_INDEP: begin
                interlock = 1'b0;
                want.hi = req_hi;
                want.lo = req_lo;
            end
            default: begin
                // contention blanks both sides
                want.hi = req_hi && !req_lo;
                want.lo = req_lo && !req_hi;
            end
        endcase
        if (disable_in) begin
            want = '0;
        end
    end

endmodule

// File: rtl/hbg_channel.sv
module hbg_channel #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want_self,
    input  logic            want_other,
    input  logic            other_on,
    input  logic            interlock,
    input  logic [DT_W-1:0] limit,
    output logic            drv_q
);

    typedef struct packed {
        logic            on;
        logic [DT_W-1:0] cnt;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [DT_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + {{DT_W{1'b0}}, 1'b1};
        if (!want_self) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (!interlock) begin
            st_d.on  = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.on) begin
            st_d.cnt = '0;
        end else if (other_on || want_other) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= {1'b0, limit}) begin
            st_d.on  = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc[DT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_q = st_q.on;

endmodule

// File: rtl/halfbridge_guard.sv
module halfbridge_guard
    import hbg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic            disable_in,
    input  logic            req_hi,
    input  logic            req_lo,
    input  logic            pwm_in,
    input  logic [DT_W-1:0] dead_cfg,
    output logic            drv_hi,
    output logic            drv_lo
);

    localparam int NCH = 2;

    hbg_want_t       want;
    logic            interlock;
    logic [DT_W-1:0] limit;
    logic [NCH-1:0]  want_v;
    logic [NCH-1:0]  drv_v;

    hbg_req_map u_map (
        .mode_sel  (mode_sel),
        .disable_in(disable_in),
        .req_hi    (req_hi),
        .req_lo    (req_lo),
        .pwm_in    (pwm_in),
        .want      (want),
        .interlock (interlock)
    );

    always_comb begin
        limit = (dead_cfg == '0) ? {{(DT_W-1){1'b0}}, 1'b1} : dead_cfg;
    end

    assign want_v = {want.hi, want.lo};

    // index 1 = high side, index 0 = low side
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        hbg_channel #(.DT_W(DT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_self (want_v[g]),
            .want_other(want_v[NCH-1-g]),
            .other_on  (drv_v[NCH-1-g]),
            .interlock (interlock),
            .limit     (limit),
            .drv_q     (drv_v[g])
        );
    end

    assign drv_hi = drv_v[1];
    assign drv_lo = drv_v[0];

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       disable_in,
    input logic       req_hi,
    input logic       req_lo,
    input logic       drv_hi,
    input logic       drv_lo
);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b10) |=> !(drv_hi && drv_lo));

    assert_contention_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[0] == mode_sel[1] && req_hi && req_lo) |=> (!drv_hi && !drv_lo));

    assert_fall_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b01 && !req_hi) |=> !drv_hi);

    assert_indep_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && !disable_in) |=> (drv_hi == $past(req_hi) && drv_lo == $past(req_lo)));

    assert_disable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disable_in |=> (!drv_hi && !drv_lo));

    assert_rise_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drv_hi) && $past(mode_sel) != 2'b10) |-> !$past(drv_lo));

endmodule

bind halfbridge_guard hbg_checker u_chk (.*);

// File: tb/halfbridge_guard_bench.sv
module halfbridge_guard_bench;

    localparam int DT_W = 8;
    localparam int NV = 42;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_sel = 2'b00;
    logic            disable_in = 1'b0;
    logic            req_hi = 1'b0;
    logic            req_lo = 1'b0;
    logic            pwm_in = 1'b0;
    logic [DT_W-1:0] dead_cfg = 8'd3;
    logic            drv_hi, drv_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = !clk;

    halfbridge_guard #(.DT_W(DT_W)) u_halfbridge_guard (.*);

    // {req tag(4), mode(2), dis, rh, rl, pwm, dead(8), exp_hi, exp_lo}
    localparam logic [19:0] VEC [NV] = '{
        {4'd4, 2'd0, 4'b0000, 8'd3, 2'b00},  // 0 idle
        {4'd4, 2'd0, 4'b0100, 8'd3, 2'b00},  // 1 hi count 1
        {4'd4, 2'd0, 4'b0100, 8'd3, 2'b00},  // 2 count 2
        {4'd4, 2'd0, 4'b0100, 8'd3, 2'b10},  // 3 hi rises
        {4'd4, 2'd0, 4'b0100, 8'd3, 2'b10},  // 4
        {4'd5, 2'd0, 4'b0010, 8'd3, 2'b00},  // 5 hi falls next edge
        {4'd4, 2'd0, 4'b0010, 8'd3, 2'b00},  // 6
        {4'd4, 2'd0, 4'b0010, 8'd3, 2'b00},  // 7
        {4'd4, 2'd0, 4'b0010, 8'd3, 2'b01},  // 8 lo rises
        {4'd3, 2'd0, 4'b0110, 8'd3, 2'b00},  // 9 contention
        {4'd3, 2'd0, 4'b0110, 8'd3, 2'b00},  // 10
        {4'd10, 2'd0, 4'b0010, 8'd3, 2'b00}, // 11 recovery, lo kept
        {4'd10, 2'd0, 4'b0010, 8'd3, 2'b00}, // 12
        {4'd10, 2'd0, 4'b0010, 8'd3, 2'b01}, // 13
        {4'd3, 2'd0, 4'b0110, 8'd3, 2'b00},  // 14 contention
        {4'd10, 2'd0, 4'b0100, 8'd3, 2'b00}, // 15 recovery, hi kept
        {4'd10, 2'd0, 4'b0100, 8'd3, 2'b00}, // 16
        {4'd10, 2'd0, 4'b0100, 8'd3, 2'b10}, // 17
        {4'd5, 2'd0, 4'b0010, 8'd3, 2'b00},  // 18
        {4'd5, 2'd0, 4'b0010, 8'd3, 2'b00},  // 19 lo count 1
        {4'd5, 2'd0, 4'b0000, 8'd3, 2'b00},  // 20 cancel
        {4'd5, 2'd0, 4'b0010, 8'd3, 2'b00},  // 21 fresh count 1
        {4'd5, 2'd0, 4'b0010, 8'd3, 2'b00},  // 22
        {4'd5, 2'd0, 4'b0010, 8'd3, 2'b01},  // 23
        {4'd6, 2'd1, 4'b0001, 8'd0, 2'b00},  // 24 pwm high, zero dead cfg
        {4'd6, 2'd1, 4'b0001, 8'd0, 2'b10},  // 25
        {4'd6, 2'd1, 4'b0000, 8'd0, 2'b00},  // 26
        {4'd6, 2'd1, 4'b0000, 8'd0, 2'b01},  // 27
        {4'd6, 2'd1, 4'b0000, 8'd0, 2'b01},  // 28
        {4'd6, 2'd1, 4'b0001, 8'd2, 2'b00},  // 29
        {4'd6, 2'd1, 4'b0001, 8'd2, 2'b00},  // 30
        {4'd6, 2'd1, 4'b0001, 8'd2, 2'b10},  // 31
        {4'd7, 2'd2, 4'b0110, 8'd3, 2'b11},  // 32 independent
        {4'd7, 2'd2, 4'b0010, 8'd3, 2'b01},  // 33
        {4'd7, 2'd2, 4'b0100, 8'd3, 2'b10},  // 34
        {4'd8, 2'd0, 4'b1100, 8'd3, 2'b00},  // 35 disable
        {4'd8, 2'd0, 4'b1100, 8'd3, 2'b00},  // 36
        {4'd8, 2'd0, 4'b0100, 8'd3, 2'b00},  // 37 release, fresh count
        {4'd8, 2'd0, 4'b0100, 8'd3, 2'b00},  // 38
        {4'd8, 2'd0, 4'b0100, 8'd3, 2'b10},  // 39
        {4'd1, 2'd3, 4'b0110, 8'd3, 2'b00},  // 40 mode 11 contention
        {4'd1, 2'd3, 4'b0100, 8'd3, 2'b00}   // 41 mode 11 counts
    };

    function automatic string tag(input logic [3:0] id);
        case (id)
            4'd1: tag = "R1";
            4'd3: tag = "R3";
            4'd4: tag = "R4";
            4'd5: tag = "R5";
            4'd6: tag = "R6";
            4'd7: tag = "R7";
            4'd8: tag = "R8";
            4'd10: tag = "R10";
            default: tag = "R2";
        endcase
    endfunction

    task automatic check(input string rq, input logic ah, input logic al,
                         input logic eh, input logic el);
        n_chk++;
        if (ah !== eh || al !== el) begin
            n_bad++;
            $display("FAIL %s: drv_hi/drv_lo = %b%b, expected %b%b", rq, ah, al, eh, el);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", drv_hi, drv_lo, 1'b0, 1'b0);
        rst_n = 1'b1;
        check("R9", drv_hi, drv_lo, 1'b0, 1'b0);
        for (int i = 0; i < NV; i++) begin
            {mode_sel, disable_in, req_hi, req_lo, pwm_in, dead_cfg} = VEC[i][17:2];
            @(posedge clk);
            #5;
            check(tag(VEC[i][19:16]), drv_hi, drv_lo, VEC[i][1], VEC[i][0]);
            @(negedge clk);
        end

        // R4: a setting of ten rises on exactly the tenth edge
        disable_in = 1'b1;
        @(negedge clk);
        {mode_sel, disable_in, req_hi, req_lo, dead_cfg} = {2'd0, 1'b0, 1'b1, 1'b0, 8'd10};
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk);
            #5;
            check("R4", drv_hi, drv_lo, (k == 10), 1'b0);
        end

        // R9: asynchronous reset drops an active enable at once
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R9", drv_hi, drv_lo, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        req_hi = 1'b0;
        @(posedge clk);
        #5;
        check("R9", drv_hi, drv_lo, 1'b0, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule